// File: doc/BRIEF.md
# Addressed Three-Wire Serial Control Slave

This block is the slave end of a three-wire serial bus made of a chip-enable line, a serial clock and a data input, plus one open-drain data output. Each frame opens with an 8-bit address. The host shifts in the address while chip-enable is low, and then raises chip-enable. The address held at that rising edge picks what the rest of the frame does. It can write one of two 32-bit control registers, or it can read back a status word. A frame with any other address is ignored.

In a write frame, the bits are taken LSB first on rising serial-clock edges. The word is committed to its register when chip-enable falls, and only if exactly 32 bits arrived. A one-cycle strobe then announces the update. In a read frame, the status word is captured when chip-enable rises and is presented MSB first. The next bit appears after each falling serial-clock edge, so the host decides how many bits it takes by how many clocks it gives. The output is modelled as a pull-low enable, and it is released at every other time.

The three pins are asynchronous to the system clock. Each pin passes through a synchronizer of `SYNC_STAGES` flops and is then edge-detected in the system clock domain.

Top module: `serbus_slave`

## Requirements
- R1: After reset both control registers read zero, both update strobes are low, and the data output is released (`doPullLow` = 0).
- R2: Address bits are sampled on serial-clock rising edges while chip-enable is low. The first bit becomes bit 0 of the address byte, and only the last 8 bits count. The code 0x82 selects write of register A, 0x92 selects write of register B, and 0xA2 selects status read.
- R3: In write frames, data bits are sampled on serial-clock rising edges while chip-enable is high. The first bit received becomes bit 0 of the 32-bit word.
- R4: When chip-enable falls on an 0x82 frame that carried exactly 32 bits, `ctrlA` takes the word and `ctrlAStb` pulses for exactly one cycle.
- R5: When chip-enable falls on an 0x92 frame that carried exactly 32 bits, `ctrlB` takes the word and `ctrlBStb` pulses for exactly one cycle.
- R6: A write frame with any bit count other than 32 leaves both registers unchanged and produces no strobe.
- R7: A frame with an unrecognised address leaves both registers unchanged, produces no strobe, and keeps the data output released for the whole frame.
- R8: In a read frame, `statusIn` is captured when chip-enable rises. Its MSB is presented first, and each falling serial-clock edge advances one bit. The output shows a 1 bit as released and a 0 bit as pulled low. Once all status bits have been given out, the output stays released.
- R9: The data output is released whenever chip-enable is low.
- R10: A read frame changes neither control register.
- R11: A write commit becomes visible on `ctrlA`/`ctrlB` on the (SYNC_STAGES+1)-th rising system-clock edge after chip-enable falls at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceIn | input | 1 | Chip-enable pin (asynchronous) |
| clIn | input | 1 | Serial clock pin (asynchronous) |
| diIn | input | 1 | Serial data input pin (asynchronous) |
| statusIn | input | STATUS_W | Status word to be read out |
| doPullLow | output | 1 | Open-drain enable for the data output; 1 pulls the line low |
| ctrlA | output | DATA_BITS | Control register A |
| ctrlB | output | DATA_BITS | Control register B |
| ctrlAStb | output | 1 | One-cycle pulse when ctrlA is written |
| ctrlBStb | output | 1 | One-cycle pulse when ctrlB is written |

## Verification
Every pin change reaches the registers on the SYNC_STAGES+1-th system-clock edge after it. The bench therefore holds each serial level for four clock cycles and samples results on a falling system-clock edge that comes at least three rising edges after the pin change that caused them. Register contents are compared once chip-enable has been low for eight cycles, and each output bit is sampled just before the next serial-clock rise. One directed sequence pins the commit latency exactly: after chip-enable falls, `ctrlA` must still hold its old value after two edges and must hold the new value, with its strobe high, right after the third edge.

// File: rtl/serbus_pkg.sv
package serbus_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_WR_A = 2'd1,
    MODE_WR_B = 2'd2,
    MODE_RD   = 2'd3
  } mode_e;

  // strobes from control to datapath, plus the synchronized data bit
  typedef struct packed {
    logic bitIn;
    logic shiftAddr;
    logic shiftIn;
    logic loadOut;
    logic shiftOut;
    logic latchA;
    logic latchB;
  } strobes_t;

endpackage

// File: rtl/serbus_ctrl.sv
module serbus_ctrl
  import serbus_pkg::*;
#(
  parameter int ADDR_BITS   = 8,
  parameter int DATA_BITS   = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_BITS-1:0] ADDR_WR_A = 8'h82,
  parameter logic [ADDR_BITS-1:0] ADDR_WR_B = 8'h92,
  parameter logic [ADDR_BITS-1:0] ADDR_RD   = 8'hA2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ceIn,
  input  logic                 clIn,
  input  logic                 diIn,
  input  logic [ADDR_BITS-1:0] addrQ,
  output strobes_t             stb,
  output mode_e                mode,
  output logic                 ceLvl
);

  localparam int CNT_LIM = DATA_BITS + 1;
  localparam int CNT_W   = $clog2(CNT_LIM + 1);

  logic [SYNC_STAGES-1:0] ceSy, clSy, diSy;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          ceSy[g] <= 1'b0;
          clSy[g] <= 1'b0;
          diSy[g] <= 1'b0;
        end else begin
          ceSy[g] <= ceIn;
          clSy[g] <= clIn;
          diSy[g] <= diIn;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          ceSy[g] <= 1'b0;
          clSy[g] <= 1'b0;
          diSy[g] <= 1'b0;
        end else begin
          ceSy[g] <= ceSy[g-1];
          clSy[g] <= clSy[g-1];
          diSy[g] <= diSy[g-1];
        end
      end
    end
  end

  logic ceS, clS, ceQ, clQ;
  logic ceRise, ceFall, clRise, clFall;
  logic [CNT_W-1:0] bitCnt;
  mode_e decoded;
  logic isWr;

  assign ceS    = ceSy[SYNC_STAGES-1];
  assign clS    = clSy[SYNC_STAGES-1];
  assign ceRise = ceS & ~ceQ;
  assign ceFall = ~ceS & ceQ;
  assign clRise = clS & ~clQ;
  assign clFall = ~clS & clQ;
  assign ceLvl  = ceS;

  always_comb begin
    if (addrQ == ADDR_WR_A)      decoded = MODE_WR_A;
    else if (addrQ == ADDR_WR_B) decoded = MODE_WR_B;
    else if (addrQ == ADDR_RD)   decoded = MODE_RD;
    else                         decoded = MODE_IDLE;
  end

  assign isWr = (mode == MODE_WR_A) || (mode == MODE_WR_B);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceQ    <= 1'b0;
      clQ    <= 1'b0;
      mode   <= MODE_IDLE;
      bitCnt <= '0;
    end else begin
      ceQ <= ceS;
      clQ <= clS;
      if (ceRise) begin
        mode   <= decoded;
        bitCnt <= '0;
      end else if (ceFall) begin
        mode <= MODE_IDLE;
      end else if (clRise && ceS && isWr && bitCnt != CNT_W'(CNT_LIM)) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.bitIn     = diSy[SYNC_STAGES-1];
    stb.shiftAddr = clRise & ~ceS;
    stb.shiftIn   = clRise & ceS & isWr;
    stb.loadOut   = ceRise & (decoded == MODE_RD);
    stb.shiftOut  = clFall & ceS & (mode == MODE_RD);
    stb.latchA    = ceFall & (mode == MODE_WR_A) & (bitCnt == CNT_W'(DATA_BITS));
    stb.latchB    = ceFall & (mode == MODE_WR_B) & (bitCnt == CNT_W'(DATA_BITS));
  end

  // R6: the bit counter saturates one past a full word
  a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(CNT_LIM));

  // R10: no commit while a read frame owns the bus
  a_r10_no_latch_in_read: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RD) |-> !(stb.latchA || stb.latchB));

  // R2: at most one frame action per cycle
  a_r2_actions_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.latchA, stb.latchB, stb.shiftOut, stb.shiftIn, stb.shiftAddr}));

endmodule

// File: rtl/serbus_dpath.sv
module serbus_dpath
  import serbus_pkg::*;
#(
  parameter int ADDR_BITS = 8,
  parameter int DATA_BITS = 32,
  parameter int STATUS_W  = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             stb,
  input  logic [STATUS_W-1:0]  statusIn,
  output logic [ADDR_BITS-1:0] addrQ,
  output logic [DATA_BITS-1:0] ctrlA,
  output logic [DATA_BITS-1:0] ctrlB,
  output logic                 strobeA,
  output logic                 strobeB,
  output logic                 outBit
);

  logic [DATA_BITS-1:0] inShift;
  logic [STATUS_W-1:0]  outShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      inShift  <= '0;
      outShift <= '1;
      ctrlA    <= '0;
      ctrlB    <= '0;
      strobeA  <= 1'b0;
      strobeB  <= 1'b0;
    end else begin
      if (stb.shiftAddr) addrQ <= {stb.bitIn, addrQ[ADDR_BITS-1:1]};
      if (stb.shiftIn)   inShift <= {stb.bitIn, inShift[DATA_BITS-1:1]};
      if (stb.loadOut)       outShift <= statusIn;
      else if (stb.shiftOut) outShift <= {outShift[STATUS_W-2:0], 1'b1};
      strobeA <= stb.latchA;
      strobeB <= stb.latchB;
      if (stb.latchA) ctrlA <= inShift;
      if (stb.latchB) ctrlB <= inShift;
    end
  end

  assign outBit = outShift[STATUS_W-1];

  // R4: register A moves only on its commit strobe
  a_r4_regA_only_on_latch: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlA) |-> $past(stb.latchA));

  // R5: register B moves only on its commit strobe
  a_r5_regB_only_on_latch: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlB) |-> $past(stb.latchB));

  // R8: the output shifter moves only on capture or a falling serial clock
  a_r8_out_moves_on_shift: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outShift) |-> $past(stb.shiftOut || stb.loadOut));

endmodule

// File: rtl/serbus_slave.sv
module serbus_slave
  import serbus_pkg::*;
#(
  parameter int ADDR_BITS   = 8,
  parameter int DATA_BITS   = 32,
  parameter int STATUS_W    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ceIn,
  input  logic                 clIn,
  input  logic                 diIn,
  input  logic [STATUS_W-1:0]  statusIn,
  output logic                 doPullLow,
  output logic [DATA_BITS-1:0] ctrlA,
  output logic [DATA_BITS-1:0] ctrlB,
  output logic                 ctrlAStb,
  output logic                 ctrlBStb
);

  strobes_t stb;
  mode_e mode;
  logic ceLvl;
  logic outBit;
  logic [ADDR_BITS-1:0] addrQ;

  serbus_ctrl #(
    .ADDR_BITS(ADDR_BITS), .DATA_BITS(DATA_BITS), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceIn(ceIn), .clIn(clIn), .diIn(diIn),
    .addrQ(addrQ), .stb(stb), .mode(mode), .ceLvl(ceLvl)
  );

  serbus_dpath #(
    .ADDR_BITS(ADDR_BITS), .DATA_BITS(DATA_BITS), .STATUS_W(STATUS_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .statusIn(statusIn), .addrQ(addrQ),
    .ctrlA(ctrlA), .ctrlB(ctrlB), .strobeA(ctrlAStb), .strobeB(ctrlBStb),
    .outBit(outBit)
  );

  assign doPullLow = (mode == MODE_RD) & ~outBit;

  // R9: output released once chip-enable has been low for a cycle
  a_r9_released_ce_low: assert property (@(posedge clk) disable iff (!rstN)
    (!ceLvl && !$fell(ceLvl)) |-> !doPullLow);

  // R4: commit strobes are single-cycle pulses
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    ctrlAStb |=> !ctrlAStb);

  // R5: commit strobes are single-cycle pulses
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBStb |=> !ctrlBStb);

endmodule

// File: tb/serbus_slave_bench.sv
module serbus_slave_bench;

  localparam int DW = 32;
  localparam int SW = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceIn = 1'b0, clIn = 1'b0, diIn = 1'b0;
  logic [SW-1:0] statusIn = '0;
  logic doPullLow, ctrlAStb, ctrlBStb;
  logic [DW-1:0] ctrlA, ctrlB;

  int vectors = 0;
  int errors = 0;
  int seenA = 0, seenB = 0;
  int wantA = 0, wantB = 0;
  logic [DW-1:0] expA = '0, expB = '0;

  always #10 clk = ~clk;

  serbus_slave u_serbus_slave (
    .clk(clk), .rstN(rstN), .ceIn(ceIn), .clIn(clIn), .diIn(diIn),
    .statusIn(statusIn), .doPullLow(doPullLow), .ctrlA(ctrlA), .ctrlB(ctrlB),
    .ctrlAStb(ctrlAStb), .ctrlBStb(ctrlBStb)
  );

  always @(negedge clk) begin
    if (rstN && ctrlAStb) seenA++;
    if (rstN && ctrlBStb) seenB++;
  end

  task automatic check(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clkBit(input logic b);
    diIn = b; hold(2);
    clIn = 1'b1; hold(4);
    clIn = 1'b0; hold(2);
  endtask

  task automatic header(input logic [7:0] addr);
    for (int i = 0; i < 8; i++) clkBit(addr[i]);
    ceIn = 1'b1; hold(4);
  endtask

  function automatic logic expBit(input logic [SW-1:0] st, input int j);
    return (j < SW) ? st[SW-1-j] : 1'b1;
  endfunction

  task automatic checkRegs(input string tag);
    check(ctrlA == expA, {tag, " ctrlA"}, 64'(ctrlA), 64'(expA));
    check(ctrlB == expB, {tag, " ctrlB"}, 64'(ctrlB), 64'(expB));
    check(seenA == wantA, {tag, " strobeA count"}, 64'(seenA), 64'(wantA));
    check(seenB == wantB, {tag, " strobeB count"}, 64'(seenB), 64'(wantB));
    check(doPullLow == 1'b0, "R9 released with CE low", 64'(doPullLow), 64'd0);
  endtask

  // write-style frame; n bits of data (bits past 32 are random)
  task automatic writeFrame(input logic [7:0] addr, input int n,
                            input logic [DW-1:0] data, input string tag);
    header(addr);
    for (int i = 0; i < n; i++) begin
      if (addr != 8'h82 && addr != 8'h92 && addr != 8'hA2)
        check(doPullLow == 1'b0, "R7 unknown address keeps DO released",
              64'(doPullLow), 64'd0);
      clkBit(i < DW ? data[i] : 1'($urandom));
    end
    ceIn = 1'b0; hold(8);
    if (n == DW && addr == 8'h82) begin expA = data; wantA++; end
    if (n == DW && addr == 8'h92) begin expB = data; wantB++; end
    checkRegs(tag);
  endtask

  task automatic readFrame(input int n, input logic [SW-1:0] st);
    statusIn = st;
    header(8'hA2);
    statusIn = ~st;
    hold(2);
    for (int j = 0; j < n; j++) begin
      check(doPullLow == ~expBit(st, j), "R8 status bit MSB first",
            64'(~doPullLow), 64'(expBit(st, j)));
      clIn = 1'b1; hold(4);
      clIn = 1'b0; hold(4);
    end
    ceIn = 1'b0; hold(8);
    checkRegs("R10 read frame leaves registers");
  endtask

  initial begin
    void'($urandom(32'd1234));
    hold(3);
    rstN = 1'b1;
    hold(3);
    checkRegs("R1 reset state");

    // directed: R2 R3 R4 R5
    writeFrame(8'h82, 32, 32'h8000_0001, "R3 R4 write A LSB first");
    writeFrame(8'h92, 32, 32'hA5C3_0F1E, "R5 write B");
    // R6 wrong counts
    writeFrame(8'h82, 31, 32'h1234_5678, "R6 31 bits discarded");
    writeFrame(8'h92, 33, 32'h1234_5678, "R6 33 bits discarded");
    writeFrame(8'h82, 0, 32'h0, "R6 zero bits discarded");
    // R7 unknown addresses (one differs from 0x82 in a single bit)
    writeFrame(8'h83, 32, 32'hDEAD_BEEF, "R7 unknown address 0x83");
    writeFrame(8'h41, 32, 32'hDEAD_BEEF, "R7 bit-reversed address");
    // R2 only the last 8 address bits count
    clkBit(1'b1); clkBit(1'b1); clkBit(1'b0);
    writeFrame(8'h92, 32, 32'h0BAD_F00D, "R2 last eight address bits");
    // R8 R10 reads, including beyond status width
    readFrame(SW, 20'hA5F01);
    readFrame(SW + 5, 20'h0_0000);
    readFrame(3, 20'hFFFFE);

    // R11 exact commit latency
    begin
      logic [DW-1:0] d;
      d = 32'h5A5A_1234;
      header(8'h82);
      for (int i = 0; i < DW; i++) clkBit(d[i]);
      ceIn = 1'b0;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check(ctrlA == expA && !ctrlAStb, "R11 not yet committed after 2 edges",
            64'(ctrlA), 64'(expA));
      @(negedge clk);
      check(ctrlA == d && ctrlAStb, "R11 committed on 3rd edge", 64'(ctrlA), 64'(d));
      @(negedge clk);
      check(!ctrlAStb, "R4 strobe lasts one cycle", 64'(ctrlAStb), 64'd0);
      expA = d; wantA++;
      hold(6);
      checkRegs("R11 after commit");
    end

    // random mix
    for (int k = 0; k < 30; k++) begin
      int sel;
      logic [7:0] a;
      int n;
      sel = int'($urandom_range(0, 4));
      n = ($urandom_range(0, 3) == 0) ? int'($urandom_range(28, 36)) : DW;
      case (sel)
        0: a = 8'h82;
        1: a = 8'h92;
        2: a = 8'h82;
        default: begin
          a = 8'($urandom);
          if (a == 8'h82 || a == 8'h92 || a == 8'hA2) a = 8'h00;
        end
      endcase
      if (sel == 4 && k % 2 == 0) readFrame(int'($urandom_range(1, SW + 3)), SW'($urandom));
      else writeFrame(a, n, $urandom, "R2 R4 R5 R6 random frame");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule